// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt lines and presents the most urgent one to a processor. A rising edge on a line records a pending request. Each line can be masked. A fixed-priority resolver picks the lowest-numbered pending line that is not masked. It raises that line to the processor only when no line of equal or higher priority is still in service. When the processor acknowledges, the block returns an 8-bit vector in the same cycle. The vector is a programmed base OR'd with the winning line number. On that cycle the request is cleared and the line is marked in service.

Software drives the block through two byte-wide addresses. Address 0 takes a start-of-setup command, a read-select command and end-of-interrupt commands. A bit pattern in the written byte tells these apart. Address 1 takes the remaining setup words: the vector base, a third word that is discarded, and an optional fourth word that turns on automatic end-of-interrupt. Once setup is done, address 1 takes the mask. Reads are combinational. Address 1 returns the mask. Address 0 returns either the pending-request register or the in-service register, depending on the read-select command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF (every line masked), address-0 reads return the request register, the vector base is 0x00, the request and in-service registers are 0, and int_req is low.
- R2: A 0-to-1 transition on irq_in[k] sets request bit k one clock later. The bit stays set until that line is accepted. A line held high after acceptance does not request again.
- R3: A write to address 1 while the setup sequence is idle and no fourth word is due loads the mask. Mask bit k = 1 keeps line k from raising int_req. Address 1 reads back the mask as written.
- R4: Among pending unmasked lines the lowest index wins. While int_ack is high with int_req high, vector_valid is high and vector equals base | index.
- R5: The winner is held back while any in-service bit with an index less than or equal to the winner's is set. int_req rises once that bit is cleared.
- R6: On acceptance the winner's request bit clears, and its in-service bit sets unless automatic end-of-interrupt is on.
- R7: A write to address 0 with bit 4 = 1 starts setup, and its bit 0 records that a fourth word will follow. The next address-1 write loads the vector base. The one after that is discarded. If a fourth word is due, the next address-1 write is that word and not a mask write.
- R8: Bit 1 of the fourth setup word turns on automatic end-of-interrupt. With it on, acceptance leaves the in-service register unchanged.
- R9: A write to address 0 with bit 4 = 0 and bit 3 = 1 selects the address-0 read source: bit 0 = 1 gives the request register, bit 0 = 0 gives the in-service register.
- R10: A write to address 0 with bits 4 and 3 both 0 is an end-of-interrupt command. Code 001 in bits 7:5 clears the lowest set in-service bit. Code 011 clears the in-service bit numbered by bits 2:0. Any other code changes nothing.
- R11: When an acceptance and a register write fall in the same cycle, the write acts on the state left after the acceptance. For example, a non-specific end-of-interrupt clears the bit just set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N_LINES | Interrupt lines, rising edge requests |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when rd_en is low |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vector | output | 8 | Vector of the accepted line, valid with vector_valid |
| vector_valid | output | 1 | High on the cycle an acknowledge is accepted |

## Verification
The bench builds the block with its default of eight lines and an 8-bit data path, so every line index and every 3-bit end-of-interrupt field is in use. With these values the bench can hold a line in service while lines both below and above it in priority are pending. It can also leave one setup word undone while the fourth-word flag is set, and make an acknowledge and an end-of-interrupt write fall on the same clock edge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_SKIP = 2'd2
  } seq_t;

  localparam int BYTE_W     = 8;
  localparam int CMD_INIT_B = 4;
  localparam int CMD_RSEL_B = 3;
  localparam logic [2:0] EOI_LOWEST = 3'b001;
  localparam logic [2:0] EOI_NUMBER = 3'b011;
endpackage

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [N_LINES-1:0] mask,
  output logic [BYTE_W-1:0]  base,
  output logic               auto_eoi,
  output logic               show_req,
  output logic               eoi_low,
  output logic               eoi_num
);
  seq_t seq_q;
  logic want4_q;
  logic wr_cmd, wr_dat;

  assign wr_cmd = wr_en && !addr;
  assign wr_dat = wr_en && addr;

  assign eoi_low = wr_cmd && !wdata[CMD_INIT_B] && !wdata[CMD_RSEL_B]
                   && (wdata[7:5] == EOI_LOWEST);
  assign eoi_num = wr_cmd && !wdata[CMD_INIT_B] && !wdata[CMD_RSEL_B]
                   && (wdata[7:5] == EOI_NUMBER);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q    <= SEQ_IDLE;
      want4_q  <= 1'b0;
      mask     <= '1;
      base     <= '0;
      auto_eoi <= 1'b0;
      show_req <= 1'b1;
    end else begin
      if (wr_cmd) begin
        if (wdata[CMD_INIT_B]) begin
          want4_q <= wdata[0];
          seq_q   <= SEQ_BASE;
        end else if (wdata[CMD_RSEL_B]) begin
          show_req <= wdata[0];
        end
      end
      if (wr_dat) begin
        case (seq_q)
          SEQ_BASE: begin
            base  <= wdata;
            seq_q <= SEQ_SKIP;
          end
          SEQ_SKIP: seq_q <= SEQ_IDLE;
          default: begin
            if (want4_q) begin
              auto_eoi <= wdata[1];
              want4_q  <= 1'b0;
            end else begin
              mask <= wdata[N_LINES-1:0];
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] take,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] rise;

  assign rise = irq_in & ~line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      pend   <= '0;
    end else begin
      line_q <= irq_in;
      pend   <= (pend & ~take) | rise;
    end
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] pend,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] insvc,
  output logic               win_ok,
  output logic [IDX_W-1:0]   win_idx,
  output logic [N_LINES-1:0] win_hot
);
  logic [N_LINES-1:0] live;
  logic               live_any, svc_any;
  logic [IDX_W-1:0]   svc_idx;

  assign live = pend & ~mask;

  always_comb begin
    win_idx  = '0;
    live_any = 1'b0;
    svc_idx  = '0;
    svc_any  = 1'b0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (live[i]) begin
        win_idx  = i[IDX_W-1:0];
        live_any = 1'b1;
      end
      if (insvc[i]) begin
        svc_idx = i[IDX_W-1:0];
        svc_any = 1'b1;
      end
    end
  end

  assign win_ok  = live_any && !(svc_any && (svc_idx <= win_idx));
  assign win_hot = {{(N_LINES-1){1'b0}}, 1'b1} << win_idx;
endmodule

// File: rtl/pic_isr_reg.sv
module pic_isr_reg #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [N_LINES-1:0] acc_hot,
  input  logic               auto_eoi,
  input  logic               eoi_low,
  input  logic               eoi_num,
  input  logic [2:0]         eoi_sel,
  output logic [N_LINES-1:0] insvc
);
  logic [N_LINES-1:0] after_acc, after_eoi, sel_hot;

  always_comb begin
    after_acc = insvc;
    if (accept && !auto_eoi) after_acc = insvc | acc_hot;
    sel_hot = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (eoi_sel == 3'(i)) sel_hot[i] = 1'b1;
    end
    after_eoi = after_acc;
    if (eoi_low)      after_eoi = after_acc & (after_acc - 1'b1);
    else if (eoi_num) after_eoi = after_acc & ~sel_hot;
  end

  always_ff @(posedge clk) begin
    if (rst) insvc <= '0;
    else     insvc <= after_eoi;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               int_req,
  input  logic               int_ack,
  output logic [7:0]         vector,
  output logic               vector_valid
);
  logic [N_LINES-1:0] mask_q, pend_q, insvc_q, win_hot, take;
  logic [BYTE_W-1:0]  base_q;
  logic               auto_eoi_q, show_req_q, eoi_low, eoi_num, win_ok, accept;
  logic [IDX_W-1:0]   win_idx;
  logic [BYTE_W-1:0]  mask_rd, pend_rd, svc_rd;

  pic_cmd_regs #(.N_LINES(N_LINES)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask(mask_q), .base(base_q), .auto_eoi(auto_eoi_q), .show_req(show_req_q),
    .eoi_low(eoi_low), .eoi_num(eoi_num)
  );

  pic_req_latch #(.N_LINES(N_LINES)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in), .take(take), .pend(pend_q)
  );

  pic_resolver #(.N_LINES(N_LINES)) u_res (
    .pend(pend_q), .mask(mask_q), .insvc(insvc_q),
    .win_ok(win_ok), .win_idx(win_idx), .win_hot(win_hot)
  );

  pic_isr_reg #(.N_LINES(N_LINES)) u_isr (
    .clk(clk), .rst(rst), .accept(accept), .acc_hot(win_hot), .auto_eoi(auto_eoi_q),
    .eoi_low(eoi_low), .eoi_num(eoi_num), .eoi_sel(wdata[2:0]), .insvc(insvc_q)
  );

  assign accept       = int_ack && win_ok;
  assign take         = accept ? win_hot : '0;
  assign int_req      = win_ok;
  assign vector_valid = accept;
  assign vector       = accept ? (base_q | BYTE_W'(win_idx)) : '0;

  always_comb begin
    mask_rd = '1;
    mask_rd[N_LINES-1:0] = mask_q;
    pend_rd = '0;
    pend_rd[N_LINES-1:0] = pend_q;
    svc_rd = '0;
    svc_rd[N_LINES-1:0] = insvc_q;
    if (!rd_en)         rdata = '0;
    else if (addr)      rdata = mask_rd;
    else if (show_req_q) rdata = pend_rd;
    else                rdata = svc_rd;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] irq_in,
  input logic               wr_en,
  input logic               addr,
  input logic [7:0]         wdata,
  input logic               int_req,
  input logic               vector_valid,
  input logic [7:0]         vector,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] insvc,
  input logic [N_LINES-1:0] mask,
  input logic               auto_eoi
);
  logic [N_LINES-1:0] line_d;
  logic [IDX_W-1:0]   vidx;
  logic               eoi_wr;

  always_ff @(posedge clk) begin
    if (rst) line_d <= '0;
    else     line_d <= irq_in;
  end

  assign vidx   = vector[IDX_W-1:0];
  assign eoi_wr = wr_en && !addr && !wdata[4] && !wdata[3];

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask) |-> !int_req); // R3
  AST_REQ_HAS_LIVE_LINE: assert property (@(posedge clk) disable iff (rst)
    int_req |-> ((pend & ~mask) != '0)); // R4
  AST_ACCEPT_CLEARS_REQ: assert property (@(posedge clk) disable iff (rst)
    (vector_valid && !(irq_in[vidx] && !line_d[vidx])) |=> !pend[$past(vidx)]); // R6
  AST_ACCEPT_SETS_SVC: assert property (@(posedge clk) disable iff (rst)
    (vector_valid && !auto_eoi && !eoi_wr) |=> insvc[$past(vidx)]); // R6
  AST_AUTO_EOI_KEEPS_SVC: assert property (@(posedge clk) disable iff (rst)
    (vector_valid && auto_eoi && !wr_en) |=> (insvc == $past(insvc))); // R8
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .int_req(int_req), .vector_valid(vector_valid), .vector(vector),
  .pend(pend_q), .insvc(insvc_q), .mask(mask_q), .auto_eoi(auto_eoi_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, int_ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vector;
  logic       int_req, vector_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl #(.N_LINES(8)) u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .int_req(int_req), .int_ack(int_ack),
    .vector(vector), .vector_valid(vector_valid)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic line(input int k, input logic v);
    @(negedge clk); irq_in[k] = v;
    @(negedge clk);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); int_ack = 1'b1;
    #1 v = vector_valid ? vector : 8'hEE;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic read_svc(output logic [7:0] d);
    wr(1'b0, 8'h0A); rd(1'b0, d); wr(1'b0, 8'h0B);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b1, d); chk("R1 mask after reset", d, 8'hFF);
    rd(1'b0, d); chk("R1 request reg after reset", d, 8'h00);
    chk("R1 int_req after reset", {7'b0, int_req}, 8'h00);
    read_svc(d); chk("R1 in-service after reset", d, 8'h00);
  endtask

  task automatic t_init;
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'hAA); wr(1'b1, 8'h00);
    rd(1'b1, d); chk("R7 setup words leave mask", d, 8'hFF);
    wr(1'b1, 8'h04);
    rd(1'b1, d); chk("R3 mask readback", d, 8'h04);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    line(2, 1'b1);
    chk("R3 masked line quiet", {7'b0, int_req}, 8'h00);
    rd(1'b0, d); chk("R2 edge latched", d, 8'h04);
    wr(1'b1, 8'h00);
    chk("R3 unmasked line requests", {7'b0, int_req}, 8'h01);
    ack(d); chk("R4 vector base|2", d, 8'h42);
    rd(1'b0, d); chk("R6 request cleared", d, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R9 read in-service", d, 8'h04);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R9 read request", d, 8'h00);
    line(2, 1'b0);
  endtask

  task automatic t_block;
    logic [7:0] d;
    line(5, 1'b1);
    chk("R5 lower line blocked", {7'b0, int_req}, 8'h00);
    line(1, 1'b1);
    chk("R5 higher line passes", {7'b0, int_req}, 8'h01);
    ack(d); chk("R4 vector base|1", d, 8'h41);
    read_svc(d); chk("R6 nested in-service", d, 8'h06);
    wr(1'b0, 8'h20); read_svc(d); chk("R10 non-specific clears lowest", d, 8'h04);
    chk("R5 still blocked by line 2", {7'b0, int_req}, 8'h00);
    wr(1'b0, 8'h40); read_svc(d); chk("R10 unknown code ignored", d, 8'h04);
    wr(1'b0, 8'h62); read_svc(d); chk("R10 specific clears line 2", d, 8'h00);
    chk("R5 released after clear", {7'b0, int_req}, 8'h01);
    ack(d); chk("R4 vector base|5", d, 8'h45);
    wr(1'b0, 8'h65); read_svc(d); chk("R10 specific clears line 5", d, 8'h00);
    line(1, 1'b0); line(5, 1'b0);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    @(negedge clk); irq_in[3] = 1'b1; irq_in[6] = 1'b1;
    @(negedge clk);
    ack(d); chk("R4 line 3 beats line 6", d, 8'h43);
    wr(1'b0, 8'h63);
    ack(d); chk("R4 line 6 next", d, 8'h46);
    wr(1'b0, 8'h66);
    rd(1'b0, d); chk("R2 both requests consumed", d, 8'h00);
    @(negedge clk); irq_in[3] = 1'b0; irq_in[6] = 1'b0;
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    line(0, 1'b1);
    @(negedge clk); int_ack = 1'b1; wr_en = 1'b1; addr = 1'b0; wdata = 8'h20;
    #1 d = vector_valid ? vector : 8'hEE;
    @(negedge clk); int_ack = 1'b0; wr_en = 1'b0;
    chk("R11 vector on shared cycle", d, 8'h40);
    read_svc(d); chk("R11 eoi after acceptance", d, 8'h00);
    line(0, 1'b0);
  endtask

  task automatic t_auto;
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h55); wr(1'b1, 8'h02);
    rd(1'b1, d); chk("R7 fourth word not a mask write", d, 8'h00);
    line(4, 1'b1);
    ack(d); chk("R7 new base in vector", d, 8'h84);
    read_svc(d); chk("R8 auto eoi leaves in-service", d, 8'h00);
    chk("R2 held line no retrigger", {7'b0, int_req}, 8'h00);
    line(4, 1'b0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_init();
    t_mask();
    t_block();
    t_prio();
    t_same_cycle();
    t_auto();
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      report();
    end
  end
endmodule